// File: doc/BRIEF.md
# Three-State Serial Word Receiver with Label-Bit Acceptance Filter

This block receives 32-bit words from a return-to-zero, three-state avionics line. Two comparator flags arrive from the analog front end: one says the line holds a valid positive (ONE) level and the other says it holds a valid negative (ZERO) level. When neither flag is set, the line is at NULL. The block samples these flags on a strobe taken from the master clock divided by 10 or by 80. It checks that each bit cell has a clean shape and shifts the bits into a word, least significant bit first.

A complete word can be screened before it is kept. When screening is on, the two bits in word positions 9 and 10 must equal two programmed control bits. A word that passes is copied into a holding register and raises a ready flag. The host reads the holding register as two 16-bit halves, low half first. Reading the high half after the low half clears the flag. A new word that arrives before the host has read the previous one replaces it and raises an overrun flag.

Top module: `arinc_rx_top`

## Requirements
- R1: The sample strobe fires once every 10 master clocks when `rate_slow` is 0 and once every 80 when it is 1. The strobe starts counting on the third rising edge after `rst_n` is released. A bit cell is exactly 10 strobes long: 5 strobes of a steady ONE (`line_one`=1, `line_zero`=0) or a steady ZERO (`line_one`=0, `line_zero`=1), then 5 strobes of NULL (both flags 0).
- R2: The first bit received is ARINC bit 1 and is stored in word bit 0. `rd_data_lo` holds word bits 15..0 (ARINC bits 1 to 16) and `rd_data_hi` holds word bits 31..16 (ARINC bits 17 to 32).
- R3: A word completes at the first strobe that sees NULL after the high half of its 32nd bit. If that word is accepted, `data_ready` and the data outputs change on the second master clock edge after that strobe edge.
- R4: When `filt_en` is 1, a word is accepted only if word bit 8 (ARINC bit 9) equals `filt_b9` and word bit 9 (ARINC bit 10) equals `filt_b10`. A rejected word leaves all outputs unchanged. When `filt_en` is 0, every complete word is accepted.
- R5: A NULL that lasts longer than 5 strobes inside a word, where a bit's high half is due, discards the word. This also covers a word cut short before its 32nd bit.
- R6: A word is discarded if any strobe sees both flags set, if a high half is not exactly 5 strobes long, or if the level changes between ONE and ZERO within a high half.
- R7: Before the first bit of a word, the line must show at least 40 consecutive NULL strobes (4 bit times). The count starts after reset, after the previous word's last high half, or after a discard. A word that starts sooner is dropped whole.
- R8: A `rd_hi` pulse clears `data_ready` only if an `rd_lo` pulse came earlier while `data_ready` was set. A `rd_hi` pulse on its own changes nothing.
- R9: A word accepted while `data_ready` is set replaces the held data and sets `overrun`. `overrun` clears together with `data_ready` when the host completes a read.
- R10: While reset is applied, `data_ready` and `overrun` are 0 and both data halves are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_one | input | 1 | Comparator flag: line at valid ONE level |
| line_zero | input | 1 | Comparator flag: line at valid ZERO level |
| rate_slow | input | 1 | 0: strobe every 10 clocks; 1: strobe every 80 clocks |
| filt_en | input | 1 | Enables the acceptance filter on bits 9 and 10 |
| filt_b9 | input | 1 | Required value of ARINC bit 9 |
| filt_b10 | input | 1 | Required value of ARINC bit 10 |
| rd_lo | input | 1 | One-cycle read strobe for the low half |
| rd_hi | input | 1 | One-cycle read strobe for the high half |
| data_ready | output | 1 | An accepted word waits to be read |
| overrun | output | 1 | An unread word was replaced |
| rd_data_lo | output | 16 | Held word bits 15..0 |
| rd_data_hi | output | 16 | Held word bits 31..16 |

## Verification
The hardest case to reach from the ports is a word that is correct bit by bit but still has to be rejected because it began before the required 40-NULL gap had passed. To create it, the stimulus sends a good word and follows it with only 20 NULL strobes before the next one. The bench then checks that the first word is still held and that no overrun appeared. The malformed cases are also reached at the ports. Each stretches, breaks or cuts short one bit of an otherwise good word: a missing high half, both flags set, a high half one strobe too long, and a word stopped after 20 bits. After each one, the bench checks that the outputs are unchanged and that the next good word is received normally.

// File: rtl/arx_pkg.sv
package arx_pkg;

  // Line FSM states
  typedef enum logic [1:0] {
    LN_GAP   = 2'd0,   // counting NULL strobes before a word may start
    LN_ARMED = 2'd1,   // gap satisfied, waiting for the first high half
    LN_HIGH  = 2'd2,   // inside the high half of a bit cell
    LN_LOW   = 2'd3    // inside the return-to-NULL half of a bit cell
  } ln_state_e;

  // Positions (0-based) of the two label bits used by the acceptance filter
  localparam int ARX_SEL_A_IDX = 8;
  localparam int ARX_SEL_B_IDX = 9;

endpackage

// File: rtl/arx_rst_sync.sv
module arx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/arx_rate_div.sv
module arx_rate_div #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick
);

  localparam int CW = $clog2(DIV_SLOW);
  localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] last;

  always_comb begin
    last  = slow ? LAST_SLOW : LAST_FAST;
    // ">=" keeps the strobe alive if the rate bit drops while the count is high
    tick  = (cnt_q >= last);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/arx_line_fsm.sv
module arx_line_fsm
  import arx_pkg::*;
#(
  parameter int WORD_BITS       = 32,
  parameter int SAMPLES_PER_BIT = 10,
  parameter int GAP_BITS        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_one,
  input  logic                 line_zero,
  output logic                 word_done,
  output logic [WORD_BITS-1:0] word
);

  localparam int HALF        = SAMPLES_PER_BIT / 2;
  localparam int GAP_SAMPLES = GAP_BITS * SAMPLES_PER_BIT;
  localparam int CNT_W       = $clog2(GAP_SAMPLES + 1);
  localparam int IDX_W       = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] HALF_C    = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_SAMPLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(WORD_BITS - 1);

  ln_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 bit_q, bit_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 done_q, done_d;

  logic is_null;
  logic is_bad;
  logic is_level;

  always_comb begin
    is_null  = !line_one && !line_zero;
    is_bad   = line_one && line_zero;
    is_level = !is_null && !is_bad;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    bit_d   = bit_q;
    word_d  = word_q;
    done_d  = 1'b0;
    if (tick) begin
      unique case (state_q)
        LN_GAP: begin
          if (is_null) begin
            if (cnt_q == GAP_LAST) begin
              state_d = LN_ARMED;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
        LN_ARMED: begin
          if (is_bad) begin
            state_d = LN_GAP;
            cnt_d   = '0;
          end else if (is_level) begin
            state_d = LN_HIGH;
            cnt_d   = CNT_W'(1);
            bit_d   = line_one;
            idx_d   = '0;
          end
        end
        LN_HIGH: begin
          if (is_level && (line_one == bit_q) && (cnt_q != HALF_C)) begin
            cnt_d = cnt_q + 1'b1;
          end else if (is_null && (cnt_q == HALF_C)) begin
            word_d[idx_q] = bit_q;
            cnt_d         = CNT_W'(1);
            if (idx_q == IDX_LAST) begin
              done_d  = 1'b1;
              state_d = LN_GAP;
            end else begin
              state_d = LN_LOW;
            end
          end else begin
            state_d = LN_GAP;
            cnt_d   = '0;
          end
        end
        LN_LOW: begin
          if (is_null && (cnt_q != HALF_C)) begin
            cnt_d = cnt_q + 1'b1;
          end else if (is_level && (cnt_q == HALF_C)) begin
            state_d = LN_HIGH;
            cnt_d   = CNT_W'(1);
            bit_d   = line_one;
            idx_d   = idx_q + 1'b1;
          end else begin
            state_d = LN_GAP;
            cnt_d   = '0;
          end
        end
        default: begin
          state_d = LN_GAP;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LN_GAP;
      cnt_q   <= '0;
      idx_q   <= '0;
      bit_q   <= 1'b0;
      word_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      bit_q   <= bit_d;
      word_q  <= word_d;
      done_q  <= done_d;
    end
  end

  assign word_done = done_q;
  assign word      = word_q;

endmodule

// File: rtl/arx_hold_regs.sv
module arx_hold_regs
  import arx_pkg::*;
#(
  parameter int WORD_BITS = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   word_done,
  input  logic [WORD_BITS-1:0]   word,
  input  logic                   filt_en,
  input  logic                   filt_a,
  input  logic                   filt_b,
  input  logic                   rd_lo,
  input  logic                   rd_hi,
  output logic                   ready,
  output logic                   overrun,
  output logic [WORD_BITS/2-1:0] half_lo,
  output logic [WORD_BITS/2-1:0] half_hi
);

  localparam int HW = WORD_BITS / 2;

  logic                 ready_q, ready_d;
  logic                 ovr_q, ovr_d;
  logic                 lo_seen_q, lo_seen_d;
  logic [WORD_BITS-1:0] data_q, data_d;
  logic                 label_ok;
  logic                 accept;

  always_comb begin
    label_ok = (word[ARX_SEL_A_IDX] == filt_a) && (word[ARX_SEL_B_IDX] == filt_b);
    accept   = word_done && (!filt_en || label_ok);
  end

  always_comb begin
    ready_d   = ready_q;
    ovr_d     = ovr_q;
    lo_seen_d = lo_seen_q;
    data_d    = data_q;
    if (rd_lo && ready_q) begin
      lo_seen_d = 1'b1;
    end
    if (rd_hi && ready_q && lo_seen_q) begin
      ready_d   = 1'b0;
      ovr_d     = 1'b0;
      lo_seen_d = 1'b0;
    end
    if (accept) begin
      data_d    = word;
      ready_d   = 1'b1;
      ovr_d     = ready_q;
      lo_seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      ovr_q     <= 1'b0;
      lo_seen_q <= 1'b0;
      data_q    <= '0;
    end else begin
      ready_q   <= ready_d;
      ovr_q     <= ovr_d;
      lo_seen_q <= lo_seen_d;
      data_q    <= data_d;
    end
  end

  logic [HW-1:0] halves [2];
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halves[h] = data_q[h*HW +: HW];
  end

  assign half_lo = halves[0];
  assign half_hi = halves[1];
  assign ready   = ready_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/arinc_rx_top.sv
module arinc_rx_top #(
  parameter int WORD_BITS       = 32,
  parameter int SAMPLES_PER_BIT = 10,
  parameter int GAP_BITS        = 4,
  parameter int DIV_FAST        = 10,
  parameter int DIV_SLOW        = 80,
  parameter int RST_STAGES      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   line_one,
  input  logic                   line_zero,
  input  logic                   rate_slow,
  input  logic                   filt_en,
  input  logic                   filt_b9,
  input  logic                   filt_b10,
  input  logic                   rd_lo,
  input  logic                   rd_hi,
  output logic                   data_ready,
  output logic                   overrun,
  output logic [WORD_BITS/2-1:0] rd_data_lo,
  output logic [WORD_BITS/2-1:0] rd_data_hi
);

  logic                 rst_n_int;
  logic                 tick;
  logic                 word_done;
  logic [WORD_BITS-1:0] asm_word;

  arx_rst_sync #(
    .STAGES (RST_STAGES)
  ) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  arx_rate_div #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) div_i (
    .clk   (clk),
    .rst_n (rst_n_int),
    .slow  (rate_slow),
    .tick  (tick)
  );

  arx_line_fsm #(
    .WORD_BITS       (WORD_BITS),
    .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
    .GAP_BITS        (GAP_BITS)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (tick),
    .line_one  (line_one),
    .line_zero (line_zero),
    .word_done (word_done),
    .word      (asm_word)
  );

  arx_hold_regs #(
    .WORD_BITS (WORD_BITS)
  ) hold_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .word_done (word_done),
    .word      (asm_word),
    .filt_en   (filt_en),
    .filt_a    (filt_b9),
    .filt_b    (filt_b10),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .ready     (data_ready),
    .overrun   (overrun),
    .half_lo   (rd_data_lo),
    .half_hi   (rd_data_hi)
  );

endmodule

// File: rtl/arx_checker.sv
module arx_checker #(
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          word_done,
  input logic          word_b9,
  input logic          word_b10,
  input logic          filt_en,
  input logic          filt_b9,
  input logic          filt_b10,
  input logic          rd_hi,
  input logic          data_ready,
  input logic          overrun,
  input logic [HW-1:0] rd_data_lo,
  input logic [HW-1:0] rd_data_hi
);

  AST_READY_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(word_done)); // R3

  AST_DATA_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(word_done) |-> ($stable(rd_data_lo) && $stable(rd_data_hi))); // R5

  AST_FILTER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !data_ready && filt_en &&
     ((word_b9 != filt_b9) || (word_b10 != filt_b10))) |=> !data_ready); // R4

  AST_READY_CLEARS_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(rd_hi)); // R8

  AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(data_ready)); // R9

  AST_OVERRUN_CLEARS_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> $fell(data_ready)); // R9

endmodule

bind arinc_rx_top arx_checker #(.HW(WORD_BITS/2)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_done  (word_done),
  .word_b9    (asm_word[8]),
  .word_b10   (asm_word[9]),
  .filt_en    (filt_en),
  .filt_b9    (filt_b9),
  .filt_b10   (filt_b10),
  .rd_hi      (rd_hi),
  .data_ready (data_ready),
  .overrun    (overrun),
  .rd_data_lo (rd_data_lo),
  .rd_data_hi (rd_data_hi)
);

// File: tb/arinc_rx_top_tb_top.sv
module arinc_rx_top_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, line_one, line_zero, rate_slow, filt_en, filt_b9, filt_b10;
  logic        rd_lo, rd_hi;
  logic        data_ready, overrun;
  logic [15:0] rd_data_lo, rd_data_hi;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  arinc_rx_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_one   (line_one),
    .line_zero  (line_zero),
    .rate_slow  (rate_slow),
    .filt_en    (filt_en),
    .filt_b9    (filt_b9),
    .filt_b10   (filt_b10),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .data_ready (data_ready),
    .overrun    (overrun),
    .rd_data_lo (rd_data_lo),
    .rd_data_hi (rd_data_hi)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_ready, m_ovr, m_lo_seen, m_pend, expect_done;
  logic [31:0] m_data, w_pending;
  int          pcnt, edges;

  always @(posedge clk) begin
    bit old_ready, old_lo, acc, tk;
    int dv;
    if (!rst_n) begin
      m_ready = 0; m_ovr = 0; m_lo_seen = 0; m_data = '0;
      m_pend = 0; pcnt = 0; edges = 0;
    end else begin
      old_ready = m_ready;
      old_lo    = m_lo_seen;
      acc = m_pend && (!filt_en ||
            (w_pending[8] == filt_b9 && w_pending[9] == filt_b10));   // R4
      if (rd_lo && old_ready) m_lo_seen = 1;
      if (rd_hi && old_ready && old_lo) begin                          // R8
        m_ready = 0; m_ovr = 0; m_lo_seen = 0;
      end
      if (acc) begin                                                   // R9
        m_data = w_pending; m_ready = 1; m_ovr = old_ready; m_lo_seen = 0;
      end
      m_pend = 0;
      if (edges >= 2) begin                                            // R1
        dv = rate_slow ? 80 : 10;
        tk = (pcnt >= dv - 1);
        pcnt = tk ? 0 : pcnt + 1;
        if (tk && expect_done && !line_one && !line_zero) begin       // R3
          expect_done = 0;
          m_pend = 1;
        end
      end
      if (edges < 2) edges++;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && edges >= 2 && !finished) begin
      chk("R3", "data_ready", {31'd0, data_ready}, {31'd0, m_ready});
      chk("R9", "overrun", {31'd0, overrun}, {31'd0, m_ovr});
      chk("R2", "rd_data_lo", {16'd0, rd_data_lo}, {16'd0, m_data[15:0]});
      chk("R2", "rd_data_hi", {16'd0, rd_data_hi}, {16'd0, m_data[31:16]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold(input logic o, input logic z, input int samples);
    line_one  = o;
    line_zero = z;
    repeat (samples * (rate_slow ? 80 : 10)) @(negedge clk);
  endtask

  task automatic idle(input int bits);
    hold(1'b0, 1'b0, bits * 10);
  endtask

  task automatic send_word(input logic [31:0] w, input bit exp_ok);
    w_pending = w;
    for (int i = 0; i < 32; i++) begin
      hold(w[i], ~w[i], 5);
      if (i == 31) begin
        line_one = 1'b0; line_zero = 1'b0;
        expect_done = exp_ok;
      end else begin
        hold(1'b0, 1'b0, 5);
      end
    end
  endtask

  // kind 0: missing high half, 1: both flags, 2: long high half, 3: truncated
  task automatic send_bad(input int kind);
    logic [31:0] w = 32'h1234_5678;
    for (int i = 0; i < 32; i++) begin
      if (kind == 3 && i >= 20) begin
        hold(1'b0, 1'b0, 10);
      end else if (kind == 0 && i == 10) begin
        hold(1'b0, 1'b0, 10);
      end else if (kind == 1 && i == 5) begin
        hold(1'b1, 1'b1, 5);
        hold(1'b0, 1'b0, 5);
      end else if (kind == 2 && i == 3) begin
        hold(1'b1, 1'b0, 6);
        hold(1'b0, 1'b0, 4);
      end else begin
        hold(w[i], ~w[i], 5);
        hold(1'b0, 1'b0, 5);
      end
    end
  endtask

  task automatic read_lo();
    rd_lo = 1'b1; @(negedge clk); rd_lo = 1'b0; @(negedge clk);
  endtask

  task automatic read_hi();
    rd_hi = 1'b1; @(negedge clk); rd_hi = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  localparam logic [31:0] W_A = 32'hA5C3_1E69;
  localparam logic [31:0] W_B = 32'h0F0F_F0F0;
  localparam logic [31:0] W_C = 32'h8000_0001;
  localparam logic [31:0] W_D = 32'h3C96_69C3;
  localparam logic [31:0] W_E = 32'hFFFF_FFFF;
  localparam logic [31:0] W_F = 32'h5555_0E00;
  localparam logic [31:0] W_G = 32'hC0DE_0D55;
  localparam logic [31:0] W_H = 32'h7E81_4A2B;

  initial begin
    rst_n = 0; line_one = 0; line_zero = 0; rate_slow = 0;
    filt_en = 0; filt_b9 = 0; filt_b10 = 0; rd_lo = 0; rd_hi = 0;
    expect_done = 0; w_pending = '0;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10", "ready in reset", {31'd0, data_ready}, 32'd0);
    chk("R10", "overrun in reset", {31'd0, overrun}, 32'd0);
    chk("R10", "data in reset", {rd_data_hi, rd_data_lo}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R3: plain word at the fast rate
    idle(5);
    send_word(W_A, 1);
    idle(5);
    chk("R3", "ready after word", {31'd0, data_ready}, 32'd1);
    chk("R2", "low half", {16'd0, rd_data_lo}, {16'd0, W_A[15:0]});
    chk("R2", "high half", {16'd0, rd_data_hi}, {16'd0, W_A[31:16]});

    // R8: high half alone does nothing, then proper order clears
    read_hi();
    chk("R8", "ready after lone rd_hi", {31'd0, data_ready}, 32'd1);
    read_lo();
    chk("R8", "ready after rd_lo", {31'd0, data_ready}, 32'd1);
    read_hi();
    chk("R8", "ready after lo+hi", {31'd0, data_ready}, 32'd0);

    // R9: overwrite of an unread word
    send_word(W_B, 1);
    idle(5);
    send_word(W_C, 1);
    idle(5);
    chk("R9", "overrun set", {31'd0, overrun}, 32'd1);
    chk("R9", "newest word held", {rd_data_hi, rd_data_lo}, W_C);
    read_lo();
    read_hi();
    chk("R9", "overrun cleared", {31'd0, overrun}, 32'd0);
    chk("R9", "ready cleared", {31'd0, data_ready}, 32'd0);

    // R5 / R6: malformed words are dropped, outputs untouched
    for (int k = 0; k < 4; k++) begin
      send_bad(k);
      idle(5);
      chk((k == 0 || k == 3) ? "R5" : "R6", "ready after bad word",
          {31'd0, data_ready}, 32'd0);
      chk((k == 0 || k == 3) ? "R5" : "R6", "data after bad word",
          {rd_data_hi, rd_data_lo}, W_C);
    end

    // R7: word started before the 4-bit gap is dropped
    send_word(W_D, 1);
    hold(1'b0, 1'b0, 20);
    send_word(W_E, 0);
    idle(5);
    chk("R7", "early word dropped", {rd_data_hi, rd_data_lo}, W_D);
    chk("R7", "no overrun from early word", {31'd0, overrun}, 32'd0);
    read_lo();
    read_hi();

    // R4: label filter
    filt_en = 1; filt_b9 = 1; filt_b10 = 0;
    send_word(W_F, 1);
    idle(5);
    chk("R4", "mismatch rejected", {31'd0, data_ready}, 32'd0);
    chk("R4", "data kept", {rd_data_hi, rd_data_lo}, W_D);
    send_word(W_G, 1);
    idle(5);
    chk("R4", "match accepted", {rd_data_hi, rd_data_lo}, W_G);
    read_lo();
    read_hi();
    filt_en = 0;

    // R1: slow rate
    rate_slow = 1;
    idle(5);
    send_word(W_H, 1);
    idle(5);
    chk("R1", "slow-rate word ready", {31'd0, data_ready}, 32'd1);
    chk("R1", "slow-rate word data", {rd_data_hi, rd_data_lo}, W_H);
    read_lo();
    read_hi();
    chk("R1", "slow-rate ready cleared", {31'd0, data_ready}, 32'd0);

    summary();
    $finish;
  end

endmodule